// File: doc/BRIEF.md
# Receive Byte Ring Engine with Delimiter and Idle Closure

This block takes bytes from a serial receiver, one per cycle on a valid strobe, and stores them into a ring of equally sized memory buffers. Each buffer has a descriptor. The descriptor holds an owner flag, a done bit, an error bit, a byte count, and a closure cause. While the engine owns a buffer, it fills the buffer and the host cannot see how full it is. The engine closes the buffer when one of three things happens: the buffer becomes full, the line has been idle for a programmable number of bit periods, or, in delimiter mode, the frame flag byte 0x7E has been stored. On closure the engine hands the descriptor to the host, pulses an interrupt, and moves to the next descriptor in the ring without help.

The host reads a descriptor through a select input. When it has consumed the data, it returns the buffer with a one-cycle give strobe. A byte that arrives while the current descriptor still belongs to the host is lost. In that case the engine raises an error interrupt, and the next buffer it closes carries the error bit. The memory itself is outside the block. The engine drives a write port whose address is the descriptor index followed by the byte offset.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset every descriptor is engine-owned (own=1), with done=0, err=0 and count=0. The current index is 0, and both interrupts are low.
- R2: When a byte arrives and the current descriptor is engine-owned, memWe is high in that same cycle. memAddr is {current index, count before the byte}, and memWdata equals the byte. The descriptor count then goes up by one.
- R3: The byte that brings the count to BUF_LEN closes the descriptor with cause 1 (full). Closure sets done=1 and own=0 and keeps the count. irqDone is high for exactly one cycle, in the cycle after the closing edge.
- R4: With delimiter mode off and a non-empty engine-owned buffer, the bitTick that completes agingLimit ticks with no byte in between closes the descriptor with cause 2 (aging). Any byte restarts the count of ticks. An empty buffer never closes. An agingLimit of 0 turns aging off.
- R5: With delimiter mode on, storing byte 0x7E closes the descriptor with cause 3 (delimiter), and aging never closes a buffer. With the mode off, 0x7E is an ordinary byte.
- R6: A 0x7E byte in delimiter mode that also fills the buffer closes it only once, with cause 3 and count BUF_LEN.
- R7: Each closure advances the current index by one, wrapping from NUM_DESC-1 to 0. The next byte goes to the new buffer.
- R8: hostGive on a host-owned descriptor makes it engine-owned and clears done, err and count. hostGive on a descriptor the engine already owns has no effect.
- R9: A byte arriving while the current descriptor is host-owned is not written (memWe low). That descriptor is left unchanged and irqErr is high in the next cycle. The next descriptor the engine closes then has err=1.
- R10: irqDone rises only in the cycle after a closure, never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | rxData holds a new byte this cycle |
| bitTick | input | 1 | One pulse per receive bit period |
| agingLimit | input | AGE_W | Idle bit periods before aging closure, 0 turns aging off |
| delimMode | input | 1 | 1: close on 0x7E and no aging |
| hostGive | input | 1 | Return a descriptor to the engine |
| hostGiveIdx | input | IDX_W | Descriptor being returned |
| descSel | input | IDX_W | Descriptor shown on the desc outputs |
| descOwnEngine | output | 1 | Selected descriptor is owned by the engine |
| descDone | output | 1 | Selected descriptor has been closed |
| descErr | output | 1 | Bytes were lost before this buffer closed |
| descCount | output | CNT_W | Bytes stored in the selected buffer |
| descCause | output | 2 | 0 none, 1 full, 2 aging, 3 delimiter |
| curIdx | output | IDX_W | Descriptor the engine is filling |
| memWe | output | 1 | Buffer memory write enable |
| memAddr | output | IDX_W+OFF_W | Buffer index and byte offset |
| memWdata | output | 8 | Byte written |
| irqDone | output | 1 | One-cycle pulse after a closure |
| irqErr | output | 1 | One-cycle pulse after a dropped byte |

## Verification
The bench looks for an off-by-one in the aging window. Such a design closes one tick early or late, or it goes on counting after a byte, which it should treat as a restart. The bench drives a 0x7E flag that also fills the buffer: a faulty priority reports the full cause or closes twice. It gives back a descriptor the engine still owns, where a careless give wipes a count that is still filling. It also overruns a ring the host has not returned. A wrong engine there writes into the host's buffer, forgets the error pulse, or never marks the next closed buffer as damaged.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_FULL  = 2'd1,
    CAUSE_AGING = 2'd2,
    CAUSE_DELIM = 2'd3
  } closeCause_t;

  typedef struct packed {
    logic        wr;
    logic        close;
    closeCause_t cause;
    logic        errMark;
  } ctrlStrobe_t;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;
endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int BUF_LEN  = 16,
  parameter int AGE_W    = 8,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int CNT_W   = $clog2(BUF_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       rxData,
  input  logic             rxValid,
  input  logic             bitTick,
  input  logic [AGE_W-1:0] agingLimit,
  input  logic             delimMode,
  input  logic [CNT_W-1:0] curCount,
  input  logic             curOwn,
  output ctrlStrobe_t      strb,
  output logic [IDX_W-1:0] curIdx,
  output logic             irqDone,
  output logic             irqErr
);
  logic [AGE_W-1:0] ageCnt;
  logic             ovrPend;
  logic             accept, drop, isFlag, fillsUp, agingArmed, ageHit;

  assign accept     = rxValid && curOwn;
  assign drop       = rxValid && !curOwn;
  assign isFlag     = delimMode && (rxData == FLAG_BYTE);
  assign fillsUp    = (curCount == CNT_W'(BUF_LEN - 1));
  assign agingArmed = !delimMode && curOwn && (curCount != '0);
  assign ageHit     = agingArmed && bitTick && !rxValid && (agingLimit != '0) &&
                      (({1'b0, ageCnt} + (AGE_W + 1)'(1)) >= {1'b0, agingLimit});

  always_comb begin
    strb.wr      = accept;
    strb.close   = (accept && (isFlag || fillsUp)) || ageHit;
    strb.errMark = ovrPend;
    if (accept) strb.cause = isFlag ? CAUSE_DELIM : CAUSE_FULL;
    else        strb.cause = CAUSE_AGING;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ageCnt  <= '0;
      ovrPend <= 1'b0;
      curIdx  <= '0;
      irqDone <= 1'b0;
      irqErr  <= 1'b0;
    end else begin
      irqDone <= strb.close;
      irqErr  <= drop;
      if (accept || strb.close)
        ageCnt <= '0;
      else if (agingArmed && bitTick && (ageCnt != '1))
        ageCnt <= ageCnt + 1'b1;
      if (drop)
        ovrPend <= 1'b1;
      else if (strb.close)
        ovrPend <= 1'b0;
      if (strb.close)
        curIdx <= (curIdx == IDX_W'(NUM_DESC - 1)) ? '0 : curIdx + 1'b1;
    end
  end
endmodule

// File: rtl/rx_ring_dpath.sv
module rx_ring_dpath
  import rx_ring_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int BUF_LEN  = 16,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int CNT_W   = $clog2(BUF_LEN + 1),
  localparam int OFF_W   = $clog2(BUF_LEN)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strb,
  input  logic [IDX_W-1:0]       curIdx,
  input  logic [7:0]             rxData,
  input  logic                   hostGive,
  input  logic [IDX_W-1:0]       hostGiveIdx,
  input  logic [IDX_W-1:0]       descSel,
  output logic [CNT_W-1:0]       curCount,
  output logic                   curOwn,
  output logic                   descOwnEngine,
  output logic                   descDone,
  output logic                   descErr,
  output logic [CNT_W-1:0]       descCount,
  output logic [1:0]             descCause,
  output logic                   memWe,
  output logic [IDX_W+OFF_W-1:0] memAddr,
  output logic [7:0]             memWdata
);
  logic [CNT_W-1:0] cntArr   [NUM_DESC];
  logic             ownArr   [NUM_DESC];
  logic             doneArr  [NUM_DESC];
  logic             errArr   [NUM_DESC];
  closeCause_t      causeArr [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : gDesc
    logic [CNT_W-1:0] cntQ;
    logic             ownQ, doneQ, errQ;
    closeCause_t      causeQ;
    logic             engHit, giveHit;

    assign engHit  = (curIdx == IDX_W'(g)) && (strb.wr || strb.close);
    assign giveHit = hostGive && (hostGiveIdx == IDX_W'(g)) && !ownQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ   <= '0;
        ownQ   <= 1'b1;
        doneQ  <= 1'b0;
        errQ   <= 1'b0;
        causeQ <= CAUSE_NONE;
      end else if (engHit) begin
        if (strb.wr) cntQ <= cntQ + 1'b1;
        if (strb.close) begin
          ownQ   <= 1'b0;
          doneQ  <= 1'b1;
          errQ   <= strb.errMark;
          causeQ <= strb.cause;
        end
      end else if (giveHit) begin
        cntQ   <= '0;
        ownQ   <= 1'b1;
        doneQ  <= 1'b0;
        errQ   <= 1'b0;
        causeQ <= CAUSE_NONE;
      end
    end

    assign cntArr[g]   = cntQ;
    assign ownArr[g]   = ownQ;
    assign doneArr[g]  = doneQ;
    assign errArr[g]   = errQ;
    assign causeArr[g] = causeQ;
  end

  assign curCount      = cntArr[curIdx];
  assign curOwn        = ownArr[curIdx];
  assign descOwnEngine = ownArr[descSel];
  assign descDone      = doneArr[descSel];
  assign descErr       = errArr[descSel];
  assign descCount     = cntArr[descSel];
  assign descCause     = causeArr[descSel];
  assign memWe         = strb.wr;
  assign memAddr       = {curIdx, curCount[OFF_W-1:0]};
  assign memWdata      = rxData;
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rx_ring_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int BUF_LEN  = 16,
  parameter int AGE_W    = 8,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int CNT_W   = $clog2(BUF_LEN + 1),
  localparam int OFF_W   = $clog2(BUF_LEN)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             rxData,
  input  logic                   rxValid,
  input  logic                   bitTick,
  input  logic [AGE_W-1:0]       agingLimit,
  input  logic                   delimMode,
  input  logic                   hostGive,
  input  logic [IDX_W-1:0]       hostGiveIdx,
  input  logic [IDX_W-1:0]       descSel,
  output logic                   descOwnEngine,
  output logic                   descDone,
  output logic                   descErr,
  output logic [CNT_W-1:0]       descCount,
  output logic [1:0]             descCause,
  output logic [IDX_W-1:0]       curIdx,
  output logic                   memWe,
  output logic [IDX_W+OFF_W-1:0] memAddr,
  output logic [7:0]             memWdata,
  output logic                   irqDone,
  output logic                   irqErr
);
  ctrlStrobe_t      strb;
  logic [CNT_W-1:0] curCount;
  logic             curOwn;

  rx_ring_ctrl #(.NUM_DESC(NUM_DESC), .BUF_LEN(BUF_LEN), .AGE_W(AGE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .bitTick(bitTick),
    .agingLimit(agingLimit), .delimMode(delimMode), .curCount(curCount), .curOwn(curOwn),
    .strb(strb), .curIdx(curIdx), .irqDone(irqDone), .irqErr(irqErr)
  );

  rx_ring_dpath #(.NUM_DESC(NUM_DESC), .BUF_LEN(BUF_LEN)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .curIdx(curIdx), .rxData(rxData),
    .hostGive(hostGive), .hostGiveIdx(hostGiveIdx), .descSel(descSel),
    .curCount(curCount), .curOwn(curOwn), .descOwnEngine(descOwnEngine),
    .descDone(descDone), .descErr(descErr), .descCount(descCount), .descCause(descCause),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk #(
  parameter int NUM_DESC = 4,
  parameter int BUF_LEN  = 16,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int CNT_W   = $clog2(BUF_LEN + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             delimMode,
  input logic             memWe,
  input logic             curOwn,
  input logic [CNT_W-1:0] curCount,
  input logic             strbWr,
  input logic             strbClose,
  input logic [1:0]       strbCause,
  input logic [IDX_W-1:0] curIdx,
  input logic             irqDone,
  input logic             irqErr
);
  // R2: a write never lands past the end of the buffer
  assert_write_in_buffer_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (curCount < CNT_W'(BUF_LEN)));

  // R3: the stored count never exceeds the buffer size
  assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    curCount <= CNT_W'(BUF_LEN));

  // R4: no closure of an empty buffer
  assert_close_nonempty_R4: assert property (@(posedge clk) disable iff (!rstN)
    strbClose |-> ((curCount != '0) || strbWr));

  // R5: aging never closes in delimiter mode
  assert_flag_mode_no_aging_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strbClose && delimMode) |-> (strbCause != 2'd2));

  // R7: the index moves only with a done interrupt
  assert_advance_with_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curIdx != $past(curIdx)) |-> irqDone);

  // R10: a done interrupt always comes with an index move
  assert_irq_means_close_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |-> (curIdx != $past(curIdx)));

  // R9: a byte meeting a host-owned buffer raises the error pulse
  assert_overrun_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !curOwn) |=> irqErr);
endmodule

bind rx_ring_dma rx_ring_chk #(.NUM_DESC(NUM_DESC), .BUF_LEN(BUF_LEN)) uChk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .delimMode(delimMode), .memWe(memWe),
  .curOwn(curOwn), .curCount(curCount), .strbWr(strb.wr), .strbClose(strb.close),
  .strbCause(strb.cause), .curIdx(curIdx), .irqDone(irqDone), .irqErr(irqErr)
);

// File: tb/sim_rx_ring_dma.sv
`timescale 1ns/1ps
module sim_rx_ring_dma;
  localparam int NUM_DESC = 4;
  localparam int BUF_LEN  = 4;
  localparam int AGE_W    = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxValid = 1'b0;
  logic       bitTick = 1'b0;
  logic [7:0] agingLimit = 8'd3;
  logic       delimMode = 1'b0;
  logic       hostGive = 1'b0;
  logic [1:0] hostGiveIdx = '0;
  logic [1:0] descSel = '0;
  logic       descOwnEngine, descDone, descErr;
  logic [2:0] descCount;
  logic [1:0] descCause;
  logic [1:0] curIdx;
  logic       memWe;
  logic [3:0] memAddr;
  logic [7:0] memWdata;
  logic       irqDone, irqErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int expIdx = 0;
  logic       sWe;
  logic [3:0] sAddr;
  logic [7:0] sData;

  always #4 clk = ~clk;

  rx_ring_dma #(.NUM_DESC(NUM_DESC), .BUF_LEN(BUF_LEN), .AGE_W(AGE_W)) u0 (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .bitTick(bitTick),
    .agingLimit(agingLimit), .delimMode(delimMode), .hostGive(hostGive),
    .hostGiveIdx(hostGiveIdx), .descSel(descSel), .descOwnEngine(descOwnEngine),
    .descDone(descDone), .descErr(descErr), .descCount(descCount), .descCause(descCause),
    .curIdx(curIdx), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .irqDone(irqDone), .irqErr(irqErr)
  );

  typedef struct packed {
    logic [7:0] data;
    logic       delim;
    logic       expClose;
    logic [1:0] expCause;
    logic [2:0] expCount;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h11, 1'b0, 1'b0, 2'd0, 3'd1},  // R2
    '{8'h7E, 1'b0, 1'b0, 2'd0, 3'd2},  // R5 flag ignored with mode off
    '{8'h33, 1'b0, 1'b0, 2'd0, 3'd3},
    '{8'h44, 1'b0, 1'b1, 2'd1, 3'd4},  // R3 full
    '{8'h55, 1'b1, 1'b0, 2'd0, 3'd1},
    '{8'h7E, 1'b1, 1'b1, 2'd3, 3'd2},  // R5 flag closes
    '{8'h01, 1'b1, 1'b0, 2'd0, 3'd1},
    '{8'h02, 1'b1, 1'b0, 2'd0, 3'd2},
    '{8'h03, 1'b1, 1'b0, 2'd0, 3'd3},
    '{8'h7E, 1'b1, 1'b1, 2'd3, 3'd4},  // R6 flag that fills
    '{8'h7E, 1'b1, 1'b1, 2'd3, 3'd1},
    '{8'hAA, 1'b0, 1'b0, 2'd0, 3'd1}   // R7 wrapped to index 0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic sendByte(input logic [7:0] d);
    rxData = d;
    rxValid = 1'b1;
    #1;
    sWe = memWe; sAddr = memAddr; sData = memWdata;
    @(posedge clk);
    @(negedge clk);
    rxValid = 1'b0;
    #1;
  endtask

  task automatic tick();
    bitTick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bitTick = 1'b0;
    #1;
  endtask

  task automatic give(input int idx);
    hostGive = 1'b1;
    hostGiveIdx = 2'(idx);
    @(posedge clk);
    @(negedge clk);
    hostGive = 1'b0;
    #1;
  endtask

  task automatic readDesc(input int idx);
    descSel = 2'(idx);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1 reset state
    for (int i = 0; i < NUM_DESC; i++) begin
      readDesc(i);
      chk("R1 own", descOwnEngine, 1);
      chk("R1 done", descDone, 0);
      chk("R1 count", descCount, 0);
    end
    chk("R1 curIdx", curIdx, 0);
    chk("R1 irqDone", irqDone, 0);
    chk("R1 irqErr", irqErr, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      delimMode = VECS[i].delim;
      sendByte(VECS[i].data);
      chk("R2 memWe", sWe, 1);
      chk("R2 memAddr", sAddr, expIdx * BUF_LEN + int'(VECS[i].expCount) - 1);
      chk("R2 memWdata", sData, VECS[i].data);
      chk("R10 irqDone", irqDone, VECS[i].expClose);
      readDesc(expIdx);
      chk("R2 count", descCount, VECS[i].expCount);
      if (VECS[i].expClose) begin
        chk("R3 done", descDone, 1);
        chk("R3 own", descOwnEngine, 0);
        chk("R6 cause", descCause, VECS[i].expCause);
        give(expIdx);
        chk("R3 irq one cycle", irqDone, 0);
        readDesc(expIdx);
        chk("R8 given own", descOwnEngine, 1);
        chk("R8 given count", descCount, 0);
        chk("R8 given done", descDone, 0);
        expIdx = (expIdx + 1) % NUM_DESC;
        chk("R7 curIdx", curIdx, expIdx);
      end
    end

    // R8 give to an engine-owned buffer is ignored
    give(0);
    readDesc(0);
    chk("R8 ignored give count", descCount, 1);
    chk("R8 ignored give own", descOwnEngine, 1);

    // R4 aging with restart
    delimMode = 1'b0;
    tick(); chk("R4 tick1", irqDone, 0);
    tick(); chk("R4 tick2", irqDone, 0);
    sendByte(8'hBB);
    chk("R4 restart addr", sAddr, 1);
    tick(); chk("R4 restart tick1", irqDone, 0);
    tick(); chk("R4 restart tick2", irqDone, 0);
    tick(); chk("R4 aging close", irqDone, 1);
    readDesc(0);
    chk("R4 aging cause", descCause, 2);
    chk("R4 aging count", descCount, 2);
    give(0);
    chk("R7 after aging", curIdx, 1);

    // R4 empty buffer never ages
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R4 empty no close", irqDone, 0);
    end
    chk("R4 empty idx", curIdx, 1);

    // R5 no aging in delimiter mode
    delimMode = 1'b1;
    sendByte(8'h10);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R5 no aging", irqDone, 0);
    end
    sendByte(8'h7E);
    chk("R5 flag close", irqDone, 1);
    readDesc(1);
    chk("R5 cause", descCause, 3);
    chk("R5 count", descCount, 2);
    give(1);

    // R4 limit zero disables aging
    delimMode = 1'b0;
    agingLimit = 8'd0;
    sendByte(8'h20);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R4 limit zero", irqDone, 0);
    end
    agingLimit = 8'd3;
    sendByte(8'h21);
    tick(); tick();
    chk("R4 before limit", irqDone, 0);
    tick();
    chk("R4 at limit", irqDone, 1);
    readDesc(2);
    chk("R4 cause 2", descCause, 2);
    give(2);

    // R9 overrun: fill the whole ring without returning
    delimMode = 1'b1;
    for (int i = 0; i < NUM_DESC; i++) begin
      sendByte(8'h7E);
      chk("R9 ring fill close", irqDone, 1);
    end
    chk("R9 idx", curIdx, 3);
    sendByte(8'h99);
    chk("R9 no write", sWe, 0);
    chk("R9 irqErr", irqErr, 1);
    chk("R9 no irqDone", irqDone, 0);
    readDesc(3);
    chk("R9 host buffer count", descCount, 1);
    chk("R9 host buffer done", descDone, 1);
    chk("R9 host buffer err", descErr, 0);
    @(negedge clk); #1;
    chk("R9 irqErr pulse", irqErr, 0);
    give(3);
    sendByte(8'h7E);
    chk("R9 close after give", irqDone, 1);
    readDesc(3);
    chk("R9 err flag", descErr, 1);
    chk("R9 err count", descCount, 1);

    finish();
  end
endmodule